// File: doc/BRIEF.md
# Interrupt Status Collector with Coalescing Timer

This block gathers single-cycle event pulses from hardware sources into a 32-bit status register and drives one level interrupt line toward the host. The host reads the status through a small 32-bit register port and acknowledges events by writing ones to the bits it has handled. An enable register decides which status bits may raise the line.

Ordinary events do not interrupt the host at once. When an unmasked event becomes pending while the line is idle, a timer measured in 32-microsecond units starts, and the line rises only when it runs out, so further events can pile up behind the first. A high-priority receive event skips this wait. A second, free-running timer can post a periodic receive event. Time advances only on a one-cycle microsecond tick supplied from outside.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the status and enable registers read 0, the timing register reads 0x0000_0040 (delay 0x40, periodic off) and `irq` is low.
- R2: A pulse on `evt_in` sets the status bit of the same index only for the source positions 31 (receive DMA), 29 (hardware error), 28 (periodic receive), 27 (transmit DMA), 25 (software error), 7 (radio-kill switch), 6 (over-temperature), 3 (software receive), 1 (wake-up) and 0 (alive), i.e. mask 0xBA00_00CB; every other status bit stays 0.
- R3: Writing to the status register (select 0) clears each bit written as 1 and leaves bits written as 0 unchanged; an event arriving in the same cycle as the clear of its bit leaves it set.
- R4: `irq` can be high only while some status bit is set whose enable bit (select 1) is also set; set but disabled bits raise nothing.
- R5: With delay value C in bits [7:0] of the timing register (select 2), the timer starts in the cycle after an unmasked bit becomes pending while the line is idle, and `irq` rises after 32*C microsecond ticks; with C = 0 it rises on the next clock edge.
- R6: A pulse on `hipri_rx` sets status bit 31 and, when enable bit 31 is set, raises `irq` on the same clock edge, whatever the delay value.
- R7: `irq` falls in the same cycle that no unmasked status bit remains set, whether by acknowledge or by clearing enable bits.
- R8: A nonzero value P in bits [15:8] of the timing register sets status bit 28 every 32*P microsecond ticks, counted from the last write to that register; P = 0 never sets it.
- R9: Register reads: select 0 status, 1 enable (all 32 bits), 2 timing with bits [31:16] reading 0, select 3 reads 0.
- R10: The delay timer advances only on cycles where `us_tick` is high.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 timing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| evt_in | input | 32 | Event pulses, one per status position |
| hipri_rx | input | 1 | High-priority receive event pulse |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| irq | output | 1 | Interrupt line to the host |

## Verification
The assertions watch, on every cycle, that unsupported status positions never set, that status bits drop only under a status write, that the line is low with all enables cleared, that a high-priority event with its enable raises the line on the next edge, and that the line falls with the last unmasked bit. The exact delay length for a sweep of delay values, the effect of withheld ticks, the periodic spacing, the clear-versus-event race and the register read map depend on counting cycles against programmed values, so only the bench scenarios show them.

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int          UNIT_TICKS = 32,
  parameter logic [7:0]  DELAY_RST  = 8'h40,
  parameter logic [7:0]  PERIOD_RST = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] evt_in,
  input  logic        hipri_rx,
  input  logic        us_tick,
  output logic        irq
);
  localparam int          PW       = $clog2(UNIT_TICKS);
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_TICKS - 1);
  localparam logic [31:0] SRC_MASK = 32'hBA00_00CB;
  localparam int          RX_BIT   = 31;
  localparam int          PER_BIT  = 28;

  logic [31:0]   st_q, en_q, st_d, clr, hi_set, per_set;
  logic [7:0]    delay_q, period_q, cnt_q, pcnt_q;
  logic [PW-1:0] pre_q, ppre_q;
  logic          run_q, fire_q;

  wire wr_st  = reg_wr && reg_sel == 2'd0;
  wire wr_en  = reg_wr && reg_sel == 2'd1;
  wire wr_cfg = reg_wr && reg_sel == 2'd2;

  wire pending  = |(st_q & en_q);
  wire bypass   = hipri_rx && en_q[RX_BIT];
  wire per_unit = us_tick && ppre_q == PRE_LAST;
  wire per_hit  = period_q != 8'd0 && per_unit && !wr_cfg &&
                  (pcnt_q + 8'd1) == period_q;

  assign clr     = wr_st ? reg_wdata : 32'd0;
  assign hi_set  = {hipri_rx, 31'd0};
  assign per_set = 32'(per_hit) << PER_BIT;
  assign st_d    = ((st_q & ~clr) | (evt_in & SRC_MASK) | hi_set | per_set) & SRC_MASK;

  assign irq = fire_q && pending;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = st_q;
      2'd1:    reg_rdata = en_q;
      2'd2:    reg_rdata = {16'd0, period_q, delay_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      en_q     <= '0;
      delay_q  <= DELAY_RST;
      period_q <= PERIOD_RST;
    end else begin
      st_q <= st_d;
      if (wr_en) en_q <= reg_wdata;
      if (wr_cfg) begin
        delay_q  <= reg_wdata[7:0];
        period_q <= reg_wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (bypass) begin
      fire_q <= 1'b1;
      run_q  <= 1'b0;
    end else if (!pending) begin
      fire_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (!fire_q && !run_q) begin
      if (delay_q == 8'd0) begin
        fire_q <= 1'b1;
      end else begin
        run_q <= 1'b1;
        cnt_q <= delay_q;
        pre_q <= '0;
      end
    end else if (run_q && us_tick) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q == 8'd1) begin
          fire_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 8'd1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppre_q <= '0;
      pcnt_q <= '0;
    end else if (wr_cfg) begin
      ppre_q <= '0;
      pcnt_q <= '0;
    end else if (us_tick) begin
      if (per_unit) begin
        ppre_q <= '0;
        pcnt_q <= per_hit ? 8'd0 : pcnt_q + 8'd1;
      end else begin
        ppre_q <= ppre_q + 1'b1;
      end
    end
  end
endmodule

module irq_coalesce_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic        hipri_rx,
  input logic        irq,
  input logic [31:0] st_q,
  input logic [31:0] en_q
);
  assert_src_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~32'hBA00_00CB) == 32'd0);

  assert_w1c_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 2'd0) |=> ((st_q & $past(st_q)) == $past(st_q)));

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 32'd0) |-> !irq);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hipri_rx && en_q[31] && !(reg_wr && reg_sel == 2'd1)) |=> irq);

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|(st_q & en_q)) |-> !irq);
endmodule

bind irq_coalesce irq_coalesce_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .hipri_rx(hipri_rx), .irq(irq), .st_q(st_q), .en_q(en_q)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_in = '0;
  logic        hipri_rx = 1'b0;
  logic        us_tick = 1'b1;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [31:0] SRC = 32'hBA00_00CB;

  always #10 clk = ~clk;

  irq_coalesce dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .hipri_rx(hipri_rx), .us_tick(us_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata; reg_sel = 2'd0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic idle();
    wr(2'd0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 status", r, 32'd0);
    rd(2'd1, r); chk("R1 enable", r, 32'd0);
    rd(2'd2, r); chk("R1 timing", r, 32'h0000_0040);
    chk("R1 irq", 32'(irq), 32'd0);

    for (int i = 0; i < 32; i++) begin
      pulse(32'd1 << i);
      rd(2'd0, r); chk("R2 single source", r, (32'd1 << i) & SRC);
      idle();
    end
    pulse(32'hFFFF_FFFF);
    rd(2'd0, r); chk("R2 all sources", r, SRC);
    idle();

    pulse(32'h3);
    wr(2'd0, 32'd0);
    rd(2'd0, r); chk("R3 write zero", r, 32'h3);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h3; evt_in = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rd(2'd0, r); chk("R3 event beats clear", r, 32'h1);
    wr(2'd0, 32'h1);
    rd(2'd0, r); chk("R3 clear", r, 32'h0);

    wr(2'd2, 32'h0);
    wr(2'd1, 32'h8);
    pulse(32'h1);
    repeat (5) @(negedge clk);
    chk("R4 masked no irq", 32'(irq), 32'd0);
    rd(2'd0, r); chk("R4 masked still set", r, 32'h1);
    wr(2'd1, 32'h1);
    @(negedge clk);
    chk("R4 unmask raises", 32'(irq), 32'd1);
    wr(2'd1, 32'h0);
    chk("R7 drop on enable clear", 32'(irq), 32'd0);
    wr(2'd1, 32'h1);
    @(negedge clk);
    wr(2'd0, 32'h1);
    chk("R7 drop on ack", 32'(irq), 32'd0);
    idle();

    foreach (r[k]) if (k < 7) begin
      logic [7:0] c;
      c = (k == 6) ? 8'h40 : ((k == 5) ? 8'd5 : 8'(k));
      wr(2'd2, {24'd0, c});
      idle();
      pulse(32'h1);
      n = 0;
      while (!irq && n < 5000) begin @(negedge clk); n++; end
      chk("R5 delay latency", 32'(n), 32'(1 + 32 * int'(c)));
      idle();
    end

    wr(2'd2, 32'h01);
    idle();
    us_tick = 1'b0;
    pulse(32'h1);
    repeat (100) @(negedge clk);
    chk("R10 no ticks no irq", 32'(irq), 32'd0);
    us_tick = 1'b1;
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk("R10 ticks resume", 32'(n), 32'd32);
    idle();

    wr(2'd2, 32'h40);
    wr(2'd1, 32'h8000_0000);
    @(negedge clk);
    hipri_rx = 1'b1;
    @(negedge clk);
    hipri_rx = 1'b0;
    chk("R6 bypass irq", 32'(irq), 32'd1);
    rd(2'd0, r); chk("R6 bit31 set", r, 32'h8000_0000);
    wr(2'd0, 32'h8000_0000);
    chk("R7 drop after bypass ack", 32'(irq), 32'd0);
    wr(2'd1, 32'h0);
    @(negedge clk);
    hipri_rx = 1'b1;
    @(negedge clk);
    hipri_rx = 1'b0;
    chk("R6 disabled no irq", 32'(irq), 32'd0);
    idle();

    wr(2'd2, 32'h0040);
    idle();
    repeat (300) @(negedge clk);
    rd(2'd0, r); chk("R8 period off", r & 32'h1000_0000, 32'd0);
    for (int p = 1; p <= 3; p += 2) begin
      wr(2'd2, 32'(p) << 8 | 32'h40);
      repeat (32 * p - 1) @(negedge clk);
      rd(2'd0, r); chk("R8 before period", r & 32'h1000_0000, 32'd0);
      @(negedge clk);
      rd(2'd0, r); chk("R8 at period", r & 32'h1000_0000, 32'h1000_0000);
      wr(2'd2, 32'h0040);
      idle();
    end

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); chk("R9 enable full width", r, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); chk("R9 timing upper zero", r, 32'h0000_FFFF);
    rd(2'd3, r); chk("R9 select 3", r, 32'd0);
    wr(2'd2, 32'h0040);
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule